// File: doc/BRIEF.md
# Pipelined Dual-Mode CORDIC Processor

This block is a fully unrolled CORDIC engine with one pipeline stage per iteration. Each stage applies one shift-and-add micro-rotation, and its shift amount is fixed by its position in the pipeline. Every operation carries a mode tag. A vectoring operation lets each stage choose its direction from the sign of the incoming y coordinate. A rotation operation makes each stage reuse the direction that stage chose for the most recent vectoring operation.

The engine accepts one operation on every clock. A typical traffic pattern is a short train of time-skewed operations: one vectoring operation measures an angle, and the rotation operations that follow it apply that same angle to other vectors. Gaps in the train (valid low) pass through as bubbles and do not disturb the stored directions. Each result leaves the pipeline as an unscaled vector together with the direction word used to produce it. Gain compensation is left to the surrounding logic.

Top module: `cordicPipe`

## Requirements
- R1: An operation presented with `inValid` high leaves the pipeline exactly 8 clocks later with `outValid` high. A cycle with `inValid` low produces `outValid` low 8 clocks later.
- R2: In a vectoring operation (`inVec`=1), stage i (counting from 0) takes direction bit d = sign bit of its y input. When d=1 the stage computes x' = x - (y>>>i) and y' = y + (x>>>i). When d=0 it computes x' = x + (y>>>i) and y' = y - (x>>>i). The shifts are arithmetic.
- R3: In a rotation operation (`inVec`=0), stage i applies the R2 equations using the direction bit it holds, whatever the sign of y.
- R4: Only a valid vectoring operation changes the direction held in a stage. Rotation operations and bubbles leave it unchanged.
- R5: Reset clears all held directions to 0 and drives `outValid`, `outX`, `outY` and `outDir` to 0.
- R6: Bit i of `outDir` is the direction that stage i used for that operation. Bit 0 belongs to the first stage.
- R7: `outVec` returns the mode tag the operation entered with.
- R8: Operations may enter on every clock with no gaps, and each one is handled independently.
- R9: Coordinates are 16-bit two's complement with 11 fractional bits. Additions wrap on overflow. As a known answer, vectoring (2048, 0) gives x=3372, y=-23 and `outDir`=8'h2E.
- R10: While `outValid` is low, `outX`, `outY` and `outDir` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation present on the input this cycle |
| inVec | input | 1 | Mode tag: 1 vectoring, 0 rotation |
| inX | input | 16 | Input x coordinate, Q5.11 |
| inY | input | 16 | Input y coordinate, Q5.11 |
| outValid | output | 1 | Result present on the output |
| outVec | output | 1 | Mode tag of the result |
| outX | output | 16 | Unscaled result x |
| outY | output | 16 | Unscaled result y |
| outDir | output | 8 | Per-stage direction word |

## Verification
A wrong held direction in any stage stays invisible until the next rotation operation reaches the output. That is 8 clocks after the rotation enters. It then shows up as one flipped bit of `outDir` and a wrong x/y pair. For this reason the stimulus places rotations right after vectorings, after bubbles, and after a reset, and then compares every bit of the direction word. A mis-wired shift or sign choice in a single stage corrupts every valid result from the same 8-clock latency on. Valid or mode skew shows up as a result that arrives one cycle early or late relative to the expected latency.

// File: rtl/cordicPipePkg.sv
package cordicPipePkg;
  // per-stage strobes from the control path to the datapath
  typedef struct packed {
    logic advance;   // a valid operation occupies this stage
    logic vecMode;   // operation is vectoring
    logic heldDir;   // direction stored by the last vectoring pass
  } stageStrobeT;
endpackage

// File: rtl/cordicCtrl.sv
module cordicCtrl
  import cordicPipePkg::*;
#(
  parameter int STAGES = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inVec,
  input  logic        yMsb [STAGES],
  output stageStrobeT strobe [STAGES],
  output logic        outValid,
  output logic        outVec
);
  logic vChain [STAGES+1];
  logic mChain [STAGES+1];

  assign vChain[0] = inValid;
  assign mChain[0] = inVec;

  for (genvar i = 0; i < STAGES; i++) begin : gStage
    logic vReg, mReg, dirReg;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        vReg   <= 1'b0;
        mReg   <= 1'b0;
        dirReg <= 1'b0;
      end else begin
        vReg <= vChain[i];
        if (vChain[i]) mReg <= mChain[i];
        if (vChain[i] && mChain[i]) dirReg <= yMsb[i];
      end
    end
    assign vChain[i+1]       = vReg;
    assign mChain[i+1]       = mReg;
    assign strobe[i].advance = vChain[i];
    assign strobe[i].vecMode = mChain[i];
    assign strobe[i].heldDir = dirReg;
  end

  assign outValid = vChain[STAGES];
  assign outVec   = mChain[STAGES];
endmodule

// File: rtl/cordicDatapath.sv
module cordicDatapath
  import cordicPipePkg::*;
#(
  parameter int STAGES = 8,
  parameter int DATA_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [DATA_W-1:0]  inX,
  input  logic [DATA_W-1:0]  inY,
  input  stageStrobeT        strobe [STAGES],
  output logic               yMsb [STAGES],
  output logic [DATA_W-1:0]  outX,
  output logic [DATA_W-1:0]  outY,
  output logic [STAGES-1:0]  outDir
);
  localparam int MSB = DATA_W - 1;

  logic signed [DATA_W-1:0] xs [STAGES+1];
  logic signed [DATA_W-1:0] ys [STAGES+1];
  logic        [STAGES-1:0] ds [STAGES+1];

  assign xs[0] = $signed(inX);
  assign ys[0] = $signed(inY);
  assign ds[0] = '0;

  for (genvar i = 0; i < STAGES; i++) begin : gStage
    logic                     dir;
    logic signed [DATA_W-1:0] xShift, yShift, xNext, yNext, xReg, yReg;
    logic        [STAGES-1:0] dNext, dReg;

    // fixed wiring shift for this iteration
    assign xShift  = xs[i] >>> i;
    assign yShift  = ys[i] >>> i;
    assign yMsb[i] = ys[i][MSB];

    always_comb begin
      dir = strobe[i].vecMode ? ys[i][MSB] : strobe[i].heldDir;
      if (dir) begin
        xNext = xs[i] - yShift;
        yNext = ys[i] + xShift;
      end else begin
        xNext = xs[i] + yShift;
        yNext = ys[i] - xShift;
      end
      dNext    = ds[i];
      dNext[i] = dir;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        xReg <= '0;
        yReg <= '0;
        dReg <= '0;
      end else if (strobe[i].advance) begin
        xReg <= xNext;
        yReg <= yNext;
        dReg <= dNext;
      end
    end

    assign xs[i+1] = xReg;
    assign ys[i+1] = yReg;
    assign ds[i+1] = dReg;
  end

  assign outX   = xs[STAGES];
  assign outY   = ys[STAGES];
  assign outDir = ds[STAGES];
endmodule

// File: rtl/cordicPipe.sv
module cordicPipe
  import cordicPipePkg::*;
#(
  parameter int STAGES = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inVec,
  input  logic [DATA_W-1:0] inX,
  input  logic [DATA_W-1:0] inY,
  output logic              outValid,
  output logic              outVec,
  output logic [DATA_W-1:0] outX,
  output logic [DATA_W-1:0] outY,
  output logic [STAGES-1:0] outDir
);
  stageStrobeT strobe [STAGES];
  logic        yMsb   [STAGES];

  cordicCtrl #(.STAGES(STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inVec(inVec),
    .yMsb(yMsb), .strobe(strobe), .outValid(outValid), .outVec(outVec)
  );

  cordicDatapath #(.STAGES(STAGES), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .inX(inX), .inY(inY), .strobe(strobe),
    .yMsb(yMsb), .outX(outX), .outY(outY), .outDir(outDir)
  );
endmodule

// File: rtl/cordicPipeChk.sv
module cordicPipeChk #(
  parameter int STAGES = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inVec,
  input logic              outValid,
  input logic              outVec,
  input logic [DATA_W-1:0] outX,
  input logic [DATA_W-1:0] outY,
  input logic [STAGES-1:0] outDir
);
  // independent delay line tracking the expected exit of each operation
  logic [STAGES-1:0] vTrack, mTrack;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vTrack <= '0;
      mTrack <= '0;
    end else begin
      vTrack <= {vTrack[STAGES-2:0], inValid};
      mTrack <= {mTrack[STAGES-2:0], inVec};
    end
  end

  // R1
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid == vTrack[STAGES-1]);
  // R7
  mode_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outVec == mTrack[STAGES-1]);
  // R10
  hold_x_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outX));
  // R10
  hold_y_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outY));
  // R10
  hold_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outDir));
endmodule

bind cordicPipe cordicPipeChk #(.STAGES(STAGES), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inVec(inVec),
  .outValid(outValid), .outVec(outVec), .outX(outX), .outY(outY),
  .outDir(outDir)
);

// File: tb/cordicPipe_tb.sv
module cordicPipe_tb_top;
  localparam int ST = 8;
  localparam int W  = 16;
  localparam int NOPS = 18;

  // row layout: {valid, vec, x, y}
  localparam logic [33:0] OPS [NOPS] = '{
    {1'b1, 1'b1,  16'sd2048,  16'sd1024},
    {1'b1, 1'b0,  16'sd1024,  16'sd0},
    {1'b1, 1'b0,  16'sd0,     16'sd2048},
    {1'b0, 1'b0,  16'sd0,     16'sd0},
    {1'b1, 1'b0, -16'sd1024,  16'sd512},
    {1'b1, 1'b1,  16'sd1500, -16'sd1800},
    {1'b1, 1'b0,  16'sd2048,  16'sd2048},
    {1'b0, 1'b1,  16'sd777,  -16'sd900},
    {1'b0, 1'b0,  16'sd0,     16'sd0},
    {1'b1, 1'b0, -16'sd500,  -16'sd700},
    {1'b1, 1'b1, -16'sd1024,  16'sd512},
    {1'b1, 1'b1,  16'sd300,   16'sd0},
    {1'b1, 1'b0,  16'sd4096, -16'sd4096},
    {1'b1, 1'b0,  16'sd100,   16'sd50},
    {1'b0, 1'b1,  16'sd0,     16'sd4000},
    {1'b1, 1'b1,  16'sd4000,  16'sd3000},
    {1'b1, 1'b0, -16'sd2048,  16'sd0},
    {1'b1, 1'b0,  16'sd0,    -16'sd2048}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inVec = 1'b0;
  logic [W-1:0] inX = '0, inY = '0;
  logic outValid, outVec;
  logic [W-1:0] outX, outY;
  logic [ST-1:0] outDir;

  int checks = 0, errors = 0;
  logic mLatch [ST];
  logic [33:0] seq [64];
  int seqLen = 0;
  logic [W-1:0] lastX, lastY, obsX, obsY;
  logic [ST-1:0] lastD, obsD;

  always #2 clk = ~clk;

  cordicPipe #(.STAGES(ST), .DATA_W(W)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inVec(inVec),
    .inX(inX), .inY(inY), .outValid(outValid), .outVec(outVec),
    .outX(outX), .outY(outY), .outDir(outDir)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference iteration built from the R2/R3/R4 equations
  task automatic model(input logic vec, input logic signed [W-1:0] xi, yi,
                       output logic signed [W-1:0] xo, yo, output logic [ST-1:0] d);
    logic signed [W-1:0] x, y, nx, ny;
    logic dd;
    x = xi; y = yi; d = '0;
    for (int i = 0; i < ST; i++) begin
      dd = vec ? y[W-1] : mLatch[i];
      if (vec) mLatch[i] = dd;
      if (dd) begin nx = x - (y >>> i); ny = y + (x >>> i); end
      else    begin nx = x + (y >>> i); ny = y - (x >>> i); end
      x = nx; y = ny; d[i] = dd;
    end
    xo = x; yo = y;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; inValid = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < ST; i++) mLatch[i] = 1'b0;
    // R5 reset values seen at the ports
    chk(outValid == 1'b0, "R5 outValid", outValid, 0);
    chk(outX == '0 && outY == '0, "R5 outX/outY", outX | outY, 0);
    chk(outDir == '0, "R5 outDir", outDir, 0);
    rstN = 1'b1;
    lastX = '0; lastY = '0; lastD = '0;
  endtask

  task automatic runSeq();
    logic eV [72];
    logic eM [72];
    logic signed [W-1:0] eX [72];
    logic signed [W-1:0] eY [72];
    logic [ST-1:0] eD [72];
    for (int c = 0; c < seqLen + ST; c++) begin
      @(negedge clk);
      if (c >= ST) begin
        int k;
        k = c - ST;
        chk(outValid == eV[k], "R1 outValid latency", outValid, eV[k]);
        if (eV[k]) begin
          chk(outVec == eM[k], "R7 outVec", outVec, eM[k]);
          chk(outX == eX[k], eM[k] ? "R2 vectoring x" : "R3 rotation x", $signed(outX), eX[k]);
          chk(outY == eY[k], eM[k] ? "R2 vectoring y" : "R3 rotation y", $signed(outY), eY[k]);
          chk(outDir == eD[k], eM[k] ? "R6 direction word" : "R4 held directions", outDir, eD[k]);
          lastX = eX[k]; lastY = eY[k]; lastD = eD[k];
          obsX = outX; obsY = outY; obsD = outDir;
        end else begin
          chk(outX == lastX && outY == lastY && outDir == lastD, "R10 hold",
              {outX, outY}, {lastX, lastY});
        end
      end
      if (c < seqLen) begin
        {inValid, inVec, inX, inY} = seq[c];
        eV[c] = seq[c][33];
        eM[c] = seq[c][32];
        if (seq[c][33]) model(seq[c][32], seq[c][31:16], seq[c][15:0], eX[c], eY[c], eD[c]);
      end else begin
        inValid = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    doReset();
    // R9 known answer, R2 vectoring of a unit vector on the x axis
    seq[0] = {1'b1, 1'b1, 16'sd2048, 16'sd0};
    seqLen = 1;
    runSeq();
    chk(obsX == 16'd3372, "R9 known x", $signed(obsX), 3372);
    chk($signed(obsY) == -16'sd23, "R9 known y", $signed(obsY), -23);
    chk(obsD == 8'h2E, "R9 known direction word", obsD, 8'h2E);

    // R8 back-to-back train with bubbles, R4 bubbles keep held directions
    for (int i = 0; i < NOPS; i++) seq[i] = OPS[i];
    seqLen = NOPS;
    runSeq();

    // R5 reset clears held directions: first rotation uses all-zero directions
    doReset();
    seq[0] = {1'b1, 1'b0, 16'sd2048, 16'sd0};
    seq[1] = {1'b1, 1'b0, -16'sd1000, 16'sd1000};
    seqLen = 2;
    runSeq();
    chk(obsD == '0, "R5 cleared directions", obsD, 0);

    // R9 wrap on overflow: large vectors, checked against the wrapping model
    seq[0] = {1'b1, 1'b1, 16'sd20000, 16'sd20000};
    seq[1] = {1'b1, 1'b0, 16'sd30000, -16'sd30000};
    seqLen = 2;
    runSeq();

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule